// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog with two consecutive timeouts, reached through a small register bus. When the run bit is set, a counter advances on every count tick. Once the configured first interval has elapsed, the block sets an expiry flag, which can drive an interrupt. It then begins a second, shorter interval. If software has not restarted the counter by the end of that interval and the reset-enable bit is set, the block emits a one-cycle reset pulse for a system reset controller.

The count tick comes from one of two sources: every cycle of the bus clock, or each rising edge of a slower free-running count clock. The count clock is synchronised into the bus clock domain, so the whole block runs on one clock. Two separate keys protect the block from runaway software. An unlock key must come immediately before any control or restart write. A restart only takes effect when a specific restart word is written.

Top module: `keyed_wdt`

## Requirements
- R1: After rst_ni is released, irq_o and wdt_rst_o are 0 and the control (0x10) and status (0x1C) registers read 0.
- R2: Writing 0x0000_5AA5 to the unlock register (0x18) arms exactly one following bus write. A write to control (0x10) or restart (0x14) that does not directly follow the key write is ignored, and any other write in between consumes the key.
- R3: An armed write of 0x0000_CAFE to restart (0x14) clears the counter and restarts the first interval. An armed write of any other value, or an unarmed write, has no effect.
- R4: The control bits are: [0] run, [1] tick source (1 = every bus clock, 0 = rising edges of cnt_clk_i), [2] interrupt enable, [3] reset enable.
- R5: Control [7:4] selects the first interval as 2^n ticks, with n = 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31 for codes 0..15. With bus-clock ticks, status bit 0 reads 1 exactly 2^n cycles after the control write that sets run, and not one cycle earlier.
- R6: Control [10:8] selects the second interval as 2^(7+code) ticks, starting when the first interval expires. At its end, wdt_rst_o is high for exactly one cycle, but only if reset enable is set and no valid restart arrived meanwhile.
- R7: Status bit 0 is the expiry flag. Writing 1 to bit 0 at 0x1C clears it without needing the key. If an expiry occurs in the same cycle, the set wins.
- R8: With WIDE_CNT = 0 (16-bit counter), a written interval code above 7 is stored and read back as 7. With WIDE_CNT = 1 (32-bit counter), codes up to 15 are kept.
- R9: irq_o equals the expiry flag ANDed with control bit 2.
- R10: Clearing the run bit returns the counter to zero and the first interval. Setting it again starts a full first interval.
- R11: Offset 0x00 reads the constant ID_VALUE. Offsets 0x14, 0x18 and any unmapped offset read 0.
- R12: With control bit 1 = 0, the counter advances once per rising edge of cnt_clk_i and holds while cnt_clk_i is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_clk_i | input | 1 | Slow count clock, sampled as data |
| wr_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | One-cycle reset pulse |

## Verification
The assertions assume that at most one write occurs per cycle and that addr_i and wdata_i are stable around each clock edge. They also assume that cnt_clk_i is slow enough for every high and low phase to last at least two bus cycles. The bench drives all bus signals at the falling edge. It toggles the count clock with two bus cycles per phase. It counts intervals in whole bus cycles from the write edge, so every expiry time is compared at the exact cycle.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFF_ID      = 5'h00;
  localparam logic [REG_AW-1:0] OFF_CTRL    = 5'h10;
  localparam logic [REG_AW-1:0] OFF_RESTART = 5'h14;
  localparam logic [REG_AW-1:0] OFF_UNLOCK  = 5'h18;
  localparam logic [REG_AW-1:0] OFF_STATUS  = 5'h1C;

  localparam logic [31:0] UNLOCK_KEY  = 32'h0000_5AA5;
  localparam logic [31:0] RESTART_KEY = 32'h0000_CAFE;

  // packs to control bits [10:0]
  typedef struct packed {
    logic [2:0] rst_sel;
    logic [3:0] int_sel;
    logic       rst_en;
    logic       irq_en;
    logic       bus_clk;
    logic       run;
  } ctrl_t;

  typedef enum logic {ST_IRQ = 1'b0, ST_RST = 1'b1} stage_t;

  // exponent of the first interval
  function automatic logic [4:0] int_exp(input logic [3:0] code);
    if (code == 4'd0)      return 5'd6;
    else if (code == 4'd1) return 5'd8;
    else if (code < 4'd8)  return {1'b0, code} + 5'd8;
    else                   return {code, 1'b1};
  endfunction

  function automatic logic [31:0] last_count(input logic [4:0] e);
    return (32'd1 << e) - 32'd1;
  endfunction
endpackage

// File: rtl/kwd_tick.sv
module kwd_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_clk_i,
  input  logic bus_sel_i,
  output logic tick_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sync_q;
  logic             rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[CHAIN-2:0], cnt_clk_i};
  end

  assign rise   = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];
  assign tick_o = bus_sel_i ? 1'b1 : rise;

  // R12: one tick per slow-clock edge
  a_r12_ext_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_sel_i && tick_o && !$past(bus_sel_i)) |=> (bus_sel_i || !tick_o));
endmodule

// File: rtl/kwd_core.sv
module kwd_core
  import kwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [3:0] int_sel_i,
  input  logic [2:0] rst_sel_i,
  input  logic       rst_en_i,
  output logic       expire_o,
  output logic       wdt_rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] int_last, rst_last;
  stage_t           stage_q;
  logic             at_last, rst_q;

  assign int_last = CNT_W'(last_count(int_exp(int_sel_i)));
  assign rst_last = CNT_W'(last_count({2'b00, rst_sel_i} + 5'd7));
  assign at_last  = cnt_q == ((stage_q == ST_IRQ) ? int_last : rst_last);
  assign expire_o = run_i && !restart_i && tick_i && at_last && (stage_q == ST_IRQ);
  assign wdt_rst_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= ST_IRQ;
      rst_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      stage_q <= ST_IRQ;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (restart_i) begin
        cnt_q   <= '0;
        stage_q <= ST_IRQ;
      end else if (tick_i) begin
        if (at_last) begin
          cnt_q <= '0;
          if (stage_q == ST_IRQ) begin
            stage_q <= ST_RST;
          end else begin
            stage_q <= ST_IRQ;
            rst_q   <= rst_en_i;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r6_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  a_r6_rst_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(rst_en_i));
  a_r10_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0 && stage_q == ST_IRQ && !wdt_rst_o));
  a_r3_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && stage_q == ST_IRQ));
  a_r5_expire_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (stage_q == ST_RST));
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter bit          WIDE_CNT = 1'b0,
  parameter logic [31:0] ID_VALUE = 32'h0057_4454
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              restart_o,
  output logic              flag_o
);
  localparam logic [3:0] INT_SEL_MAX = WIDE_CNT ? 4'hF : 4'h7;

  ctrl_t      ctrl_q;
  logic       unlocked_q, flag_q;
  logic       wr_ctrl, wr_status;
  logic [3:0] sel_in;

  assign wr_ctrl   = wr_i && (addr_i == OFF_CTRL) && unlocked_q;
  assign wr_status = wr_i && (addr_i == OFF_STATUS);
  assign restart_o = wr_i && (addr_i == OFF_RESTART) && unlocked_q && (wdata_i == RESTART_KEY);
  assign sel_in    = (wdata_i[7:4] > INT_SEL_MAX) ? INT_SEL_MAX : wdata_i[7:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      unlocked_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (wr_i) unlocked_q <= (addr_i == OFF_UNLOCK) && (wdata_i == UNLOCK_KEY);
      if (wr_ctrl) ctrl_q <= {wdata_i[10:8], sel_in, wdata_i[3:0]};
      if (expire_i)                    flag_q <= 1'b1;
      else if (wr_status && wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_ID:     rdata_o = ID_VALUE;
      OFF_CTRL:   rdata_o = {21'd0, ctrl_q};
      OFF_STATUS: rdata_o = {31'd0, flag_q};
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;

  a_r2_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CTRL && !unlocked_q) |=> $stable(ctrl_q));
  a_r2_key_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != OFF_UNLOCK) |=> !unlocked_q);
  a_r7_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && wdata_i[0] && !expire_i) |=> !flag_q);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q);
  a_r8_code_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.int_sel <= INT_SEL_MAX);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter bit          WIDE_CNT    = 1'b0,
  parameter logic [31:0] ID_VALUE    = 32'h0057_4454,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cnt_clk_i,
  input  logic        wr_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        wdt_rst_o
);
  localparam int CNT_W = WIDE_CNT ? 32 : 16;

  ctrl_t ctrl;
  logic  restart, flag, tick, expire;

  kwd_regs #(.WIDE_CNT(WIDE_CNT), .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .expire_i (expire),
    .ctrl_o   (ctrl),
    .restart_o(restart),
    .flag_o   (flag)
  );

  kwd_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .cnt_clk_i,
    .bus_sel_i(ctrl.bus_clk),
    .tick_o   (tick)
  );

  kwd_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .run_i    (ctrl.run),
    .tick_i   (tick),
    .restart_i(restart),
    .int_sel_i(ctrl.int_sel),
    .rst_sel_i(ctrl.rst_sel),
    .rst_en_i (ctrl.rst_en),
    .expire_o (expire),
    .wdt_rst_o(wdt_rst_o)
  );

  assign irq_o = flag & ctrl.irq_en;
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  localparam logic [4:0]  A_ID = 5'h00, A_CTRL = 5'h10, A_RS = 5'h14, A_UL = 5'h18, A_ST = 5'h1C;
  localparam logic [31:0] KEY_UL = 32'h5AA5, KEY_RS = 32'hCAFE, EXP_ID = 32'h0057_4454;

  logic clk = 1'b0, rst_n = 1'b0, cnt_clk = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wrst;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  keyed_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    wr_reg(A_UL, KEY_UL);
    wr_reg(A_CTRL, v);
  endtask

  task automatic quiesce();
    set_ctrl(32'h0);
    wr_reg(A_ST, 32'h1);
  endtask

  task automatic chk_flag(input string req, input logic exp);
    logic [31:0] d;
    rd_reg(A_ST, d);
    chk(req, d, {31'd0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd_reg(A_ST, d);   chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdt_rst", wrst, 0);
  endtask

  task automatic t_readmap();
    logic [31:0] d;
    rd_reg(A_ID, d);  chk("R11 id", d, EXP_ID);
    rd_reg(A_RS, d);  chk("R11 restart reads 0", d, 0);
    rd_reg(A_UL, d);  chk("R11 unlock reads 0", d, 0);
    rd_reg(5'h04, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr_reg(A_CTRL, 32'h250);
    rd_reg(A_CTRL, d); chk("R2 no key ignored", d, 0);
    set_ctrl(32'h250);
    rd_reg(A_CTRL, d); chk("R2 keyed write", d, 32'h250);
    wr_reg(A_CTRL, 32'h0);
    rd_reg(A_CTRL, d); chk("R2 key one shot", d, 32'h250);
    wr_reg(A_UL, KEY_UL);
    wr_reg(A_ST, 32'h0);
    wr_reg(A_CTRL, 32'h0);
    rd_reg(A_CTRL, d); chk("R2 key consumed by other write", d, 32'h250);
    quiesce();
  endtask

  task automatic t_cap();
    logic [31:0] d;
    set_ctrl(32'h0F0); rd_reg(A_CTRL, d); chk("R8 cap 15", d, 32'h070);
    set_ctrl(32'h0A0); rd_reg(A_CTRL, d); chk("R8 cap 10", d, 32'h070);
    set_ctrl(32'h050); rd_reg(A_CTRL, d); chk("R8 keep 5", d, 32'h050);
    quiesce();
  endtask

  task automatic t_interval(input int code, input int len);
    set_ctrl(32'h3 | (code << 4));
    repeat (len - 1) @(negedge clk);
    chk_flag($sformatf("R5 code %0d early", code), 1'b0);
    @(negedge clk);
    chk_flag($sformatf("R5 code %0d on time", code), 1'b1);
    quiesce();
  endtask

  task automatic t_rst_stage();
    set_ctrl(32'h0F);
    repeat (64) @(negedge clk);
    chk_flag("R6 first stage done", 1'b1);
    chk("R9 irq with enable", irq, 1);
    repeat (127) @(negedge clk);
    chk("R6 pulse not early", wrst, 0);
    @(negedge clk);
    chk("R6 pulse", wrst, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", wrst, 0);
    quiesce();
  endtask

  task automatic t_no_rst_en();
    logic seen = 1'b0;
    set_ctrl(32'h07);
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      if (wrst) seen = 1'b1;
    end
    chk("R6 no pulse without reset enable", seen, 0);
    quiesce();
  endtask

  task automatic t_restart();
    set_ctrl(32'h03);
    repeat (40) @(negedge clk);
    wr_reg(A_UL, KEY_UL);
    wr_reg(A_RS, KEY_RS);
    repeat (63) @(negedge clk);
    chk_flag("R3 restart delays expiry", 1'b0);
    @(negedge clk);
    chk_flag("R3 expiry after restart", 1'b1);
    quiesce();
  endtask

  task automatic t_bad_restart();
    set_ctrl(32'h03);
    repeat (40) @(negedge clk);
    wr_reg(A_UL, KEY_UL);
    wr_reg(A_RS, 32'h1234);
    repeat (21) @(negedge clk);
    chk_flag("R3 wrong word early", 1'b0);
    @(negedge clk);
    chk_flag("R3 wrong word no effect", 1'b1);
    quiesce();
    set_ctrl(32'h03);
    repeat (40) @(negedge clk);
    wr_reg(A_RS, KEY_RS);
    repeat (22) @(negedge clk);
    chk_flag("R2 unkeyed restart early", 1'b0);
    @(negedge clk);
    chk_flag("R2 unkeyed restart ignored", 1'b1);
    quiesce();
  endtask

  task automatic t_restart_in_rst();
    logic seen = 1'b0;
    set_ctrl(32'h0B);
    repeat (64) @(negedge clk);
    repeat (50) @(negedge clk);
    wr_reg(A_UL, KEY_UL);
    wr_reg(A_RS, KEY_RS);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (wrst) seen = 1'b1;
    end
    chk("R6 restart in second stage stops pulse", seen, 0);
    quiesce();
  endtask

  task automatic t_irq_w1c();
    set_ctrl(32'h03);
    repeat (64) @(negedge clk);
    chk_flag("R9 flag set", 1'b1);
    chk("R9 irq masked", irq, 0);
    set_ctrl(32'h07);
    chk("R9 irq unmasked", irq, 1);
    chk("R4 irq enable bit", irq, 1);
    wr_reg(A_ST, 32'h1);
    chk_flag("R7 w1c clears", 1'b0);
    chk("R7 irq follows clear", irq, 0);
    quiesce();
  endtask

  task automatic t_disable();
    set_ctrl(32'h03);
    repeat (40) @(negedge clk);
    set_ctrl(32'h02);
    repeat (100) @(negedge clk);
    chk_flag("R10 stopped while off", 1'b0);
    set_ctrl(32'h03);
    repeat (63) @(negedge clk);
    chk_flag("R10 full interval early", 1'b0);
    @(negedge clk);
    chk_flag("R10 full interval", 1'b1);
    quiesce();
  endtask

  task automatic pulse_cnt();
    cnt_clk = 1'b1; repeat (2) @(negedge clk);
    cnt_clk = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic t_ext();
    set_ctrl(32'h01);
    repeat (300) @(negedge clk);
    chk_flag("R12 idle count clock holds", 1'b0);
    for (int i = 0; i < 63; i++) pulse_cnt();
    repeat (6) @(negedge clk);
    chk_flag("R12 63 edges", 1'b0);
    pulse_cnt();
    repeat (6) @(negedge clk);
    chk_flag("R12 64 edges", 1'b1);
    quiesce();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run not finished, actual 200000 cycles expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readmap();
    t_lock();
    t_cap();
    t_interval(0, 64);
    t_interval(1, 256);
    t_interval(2, 1024);
    t_interval(3, 2048);
    t_rst_stage();
    t_no_rst_en();
    t_restart();
    t_bad_restart();
    t_restart_in_rst();
    t_irq_w1c();
    t_disable();
    t_ext();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule